// File: doc/BRIEF.md
# Transmit Compliance Pattern Source with Lane Polarity Correction

This block sits between the encoder and the serializer of a four-lane transmit path, and between the deserializer and the decoder of the receive path. Each lane carries one 20-bit parallel word per clock in each direction. In normal operation the transmit word passes straight through. When test mode is on, every lane sends one of three fixed compliance patterns in place of its own data. The patterns are the high-frequency toggle, the low-frequency five-and-five square wave, and the 20-bit mixed-frequency sequence.

Each lane has its own polarity control for transmit and its own for receive. When a lane's control bit is set, all 20 bits of that lane's word are inverted. This lets board-level swaps of differential pairs be undone without touching the line coding. The transmit inversion is applied after the pattern mux, so it also flips test patterns. Both directions are registered and have a latency of exactly one clock.

Bit 0 of each word is the first bit on the line. Both 10-bit-period patterns therefore fit twice into a word, and the stream stays in phase from one word to the next.

Top module: `lane_pattern_tx`

## Requirements
- R1: While the reset input is low, both output buses are all zeros.
- R2: With test mode off, the transmit word of lane L at a clock edge is the lane's input word from the previous edge. It is inverted if that lane's transmit-invert bit (mask bit L) was set.
- R3: With test mode on and select 2'b00, every lane sends 20'hAAAAA (before inversion). The serial sequence is 0,1,0,1… starting with word bit 0.
- R4: With test mode on and select 2'b01, every lane sends 20'h07C1F (before inversion). This is five ones then five zeros, twice per word.
- R5: With test mode on and select 2'b10, every lane sends 20'h2835F (before inversion). Read from bit 0 upward this is 11111010110000010100.
- R6: The reserved select 2'b11 sends the same word as select 2'b00.
- R7: Transmit inversion is applied per lane after the pattern mux. Each lane's inversion uses only its own mask bit.
- R8: The receive word of lane L is the previous-cycle receive input, inverted when receive-invert bit L was set. It does not depend on test mode, the select value or the transmit mask.
- R9: While test mode is on, the transmit data inputs have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_en | input | 1 | 1 = replace transmit data with the selected pattern |
| test_sel | input | 2 | Pattern select: 00 high, 01 low, 10 mixed, 11 reserved (acts as 00) |
| tx_inv | input | NUM_LANES | Per-lane transmit invert, bit L for lane L |
| rx_inv | input | NUM_LANES | Per-lane receive invert, bit L for lane L |
| tx_data_in | input | NUM_LANES*WORD_W | Normal transmit words, lane L at bits [L*WORD_W +: WORD_W] |
| rx_data_in | input | NUM_LANES*WORD_W | Received words, same lane packing |
| tx_data_out | output | NUM_LANES*WORD_W | Registered transmit words to the serializer |
| rx_data_out | output | NUM_LANES*WORD_W | Registered corrected receive words |

## Verification
The bench builds the block with four lanes of 20 bits. With these values every bit of both invert masks maps to a lane that is actually driven. The mixed pattern also fills exactly one word, so each of its 20 positions is compared every cycle. Random data, random masks and all four select codes are mixed, including switching between test mode and normal mode. A behavioural model built from the serial bit descriptions predicts every lane on every clock.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    SEL_HIFREQ = 2'b00,
    SEL_LOFREQ = 2'b01,
    SEL_MIXED  = 2'b10,
    SEL_RSVD   = 2'b11
  } pat_sel_e;

  localparam int unsigned   MIX_LEN   = 20;
  localparam logic [19:0]   MIX_SEQ   = 20'h2835F;
  localparam int unsigned   SQ_PERIOD = 10;

  // Line bit at serial position idx (word bit 0 goes out first).
  function automatic logic pat_bit(pat_sel_e sel, int unsigned idx);
    case (sel)
      SEL_LOFREQ: pat_bit = ((idx % SQ_PERIOD) < (SQ_PERIOD / 2));
      SEL_MIXED:  pat_bit = MIX_SEQ[idx % MIX_LEN];
      default:    pat_bit = ((idx % 2) == 1);
    endcase
  endfunction

endpackage

// File: rtl/tpg_pattern_gen.sv
module tpg_pattern_gen
  import tpg_pkg::*;
#(
  parameter int unsigned WORD_W = 20
) (
  input  pat_sel_e            sel,
  output logic [WORD_W-1:0]   word
);

  function automatic logic [WORD_W-1:0] build(pat_sel_e s);
    logic [WORD_W-1:0] w;
    for (int unsigned i = 0; i < WORD_W; i++) w[i] = pat_bit(s, i);
    return w;
  endfunction

  localparam logic [WORD_W-1:0] HI_WORD  = build(SEL_HIFREQ);
  localparam logic [WORD_W-1:0] LO_WORD  = build(SEL_LOFREQ);
  localparam logic [WORD_W-1:0] MIX_WORD = build(SEL_MIXED);

  always_comb begin
    case (sel)
      SEL_LOFREQ: word = LO_WORD;
      SEL_MIXED:  word = MIX_WORD;
      default:    word = HI_WORD;
    endcase
  end

endmodule

// File: rtl/tpg_lane.sv
module tpg_lane #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic [WORD_W-1:0] pat_word,
  input  logic              tx_inv,
  input  logic              rx_inv,
  input  logic [WORD_W-1:0] tx_in,
  input  logic [WORD_W-1:0] rx_in,
  output logic [WORD_W-1:0] tx_out,
  output logic [WORD_W-1:0] rx_out
);

  logic [WORD_W-1:0] tx_sel;
  logic [WORD_W-1:0] tx_nxt;
  logic [WORD_W-1:0] rx_nxt;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              word_en;

  assign word_en = 1'b1;

  always_comb begin
    tx_sel = test_en ? pat_word : tx_in;
    tx_nxt = tx_sel ^ {WORD_W{tx_inv}};
    rx_nxt = rx_in  ^ {WORD_W{rx_inv}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (word_en) begin
      tx_q <= tx_nxt;
      rx_q <= rx_nxt;
    end
  end

  assign tx_out = tx_q;
  assign rx_out = rx_q;

endmodule

// File: rtl/lane_pattern_tx.sv
module lane_pattern_tx
  import tpg_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned WORD_W    = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        test_en,
  input  logic [1:0]                  test_sel,
  input  logic [NUM_LANES-1:0]        tx_inv,
  input  logic [NUM_LANES-1:0]        rx_inv,
  input  logic [NUM_LANES*WORD_W-1:0] tx_data_in,
  input  logic [NUM_LANES*WORD_W-1:0] rx_data_in,
  output logic [NUM_LANES*WORD_W-1:0] tx_data_out,
  output logic [NUM_LANES*WORD_W-1:0] rx_data_out
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [WORD_W-1:0]      pat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  tpg_pattern_gen #(.WORD_W(WORD_W)) u_pat (
    .sel  (pat_sel_e'(test_sel)),
    .word (pat_word)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    tpg_lane #(.WORD_W(WORD_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .test_en  (test_en),
      .pat_word (pat_word),
      .tx_inv   (tx_inv[l]),
      .rx_inv   (rx_inv[l]),
      .tx_in    (tx_data_in[l*WORD_W +: WORD_W]),
      .rx_in    (rx_data_in[l*WORD_W +: WORD_W]),
      .tx_out   (tx_data_out[l*WORD_W +: WORD_W]),
      .rx_out   (rx_data_out[l*WORD_W +: WORD_W])
    );
  end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned WORD_W    = 20
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        test_en,
  input logic [1:0]                  test_sel,
  input logic [NUM_LANES-1:0]        tx_inv,
  input logic [NUM_LANES-1:0]        rx_inv,
  input logic [NUM_LANES*WORD_W-1:0] tx_data_in,
  input logic [NUM_LANES*WORD_W-1:0] rx_data_in,
  input logic [NUM_LANES*WORD_W-1:0] tx_data_out,
  input logic [NUM_LANES*WORD_W-1:0] rx_data_out
);

  function automatic logic [WORD_W-1:0] ref_word(pat_sel_e s);
    logic [WORD_W-1:0] w;
    for (int unsigned i = 0; i < WORD_W; i++) w[i] = pat_bit(s, i);
    return w;
  endfunction

  localparam logic [WORD_W-1:0] HI_W  = ref_word(SEL_HIFREQ);
  localparam logic [WORD_W-1:0] LO_W  = ref_word(SEL_LOFREQ);
  localparam logic [WORD_W-1:0] MIX_W = ref_word(SEL_MIXED);

  logic live_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) live_q <= 1'b0;
    else             live_q <= 1'b1;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (live_q && !$past(test_en)) |->
        tx_data_out[l*WORD_W +: WORD_W] ==
        ($past(tx_data_in[l*WORD_W +: WORD_W]) ^ {WORD_W{$past(tx_inv[l])}}));
    // R3
    hifreq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (live_q && $past(test_en) && $past(test_sel) == 2'b00) |->
        tx_data_out[l*WORD_W +: WORD_W] == (HI_W ^ {WORD_W{$past(tx_inv[l])}}));
    // R4
    lofreq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (live_q && $past(test_en) && $past(test_sel) == 2'b01) |->
        tx_data_out[l*WORD_W +: WORD_W] == (LO_W ^ {WORD_W{$past(tx_inv[l])}}));
    // R5
    mixed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (live_q && $past(test_en) && $past(test_sel) == 2'b10) |->
        tx_data_out[l*WORD_W +: WORD_W] == (MIX_W ^ {WORD_W{$past(tx_inv[l])}}));
    // R6
    reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (live_q && $past(test_en) && $past(test_sel) == 2'b11) |->
        tx_data_out[l*WORD_W +: WORD_W] == (HI_W ^ {WORD_W{$past(tx_inv[l])}}));
    // R8
    rx_fix_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      live_q |->
        rx_data_out[l*WORD_W +: WORD_W] ==
        ($past(rx_data_in[l*WORD_W +: WORD_W]) ^ {WORD_W{$past(rx_inv[l])}}));
  end

endmodule

bind lane_pattern_tx tpg_checker #(
  .NUM_LANES (NUM_LANES),
  .WORD_W    (WORD_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .test_en     (test_en),
  .test_sel    (test_sel),
  .tx_inv      (tx_inv),
  .rx_inv      (rx_inv),
  .tx_data_in  (tx_data_in),
  .rx_data_in  (rx_data_in),
  .tx_data_out (tx_data_out),
  .rx_data_out (rx_data_out)
);

// File: tb/lane_pattern_tx_test.sv
module lane_pattern_tx_test;

  localparam int NL = 4;
  localparam int W  = 20;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            test_en;
  logic [1:0]      test_sel;
  logic [NL-1:0]   tx_inv;
  logic [NL-1:0]   rx_inv;
  logic [NL*W-1:0] tx_data_in;
  logic [NL*W-1:0] rx_data_in;
  logic [NL*W-1:0] tx_data_out;
  logic [NL*W-1:0] rx_data_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [W-1:0] exp_tx [NL];
  logic [W-1:0] exp_rx [NL];
  string        tx_tag [NL];
  bit           exp_ok = 0;

  always #5 clk = ~clk;

  lane_pattern_tx #(.NUM_LANES(NL), .WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .test_sel(test_sel),
    .tx_inv(tx_inv), .rx_inv(rx_inv), .tx_data_in(tx_data_in),
    .rx_data_in(rx_data_in), .tx_data_out(tx_data_out), .rx_data_out(rx_data_out)
  );

  // Serial description of each pattern, first line bit at index 0.
  function automatic logic [W-1:0] model_pattern(int sel);
    string mix = "11111010110000010100";
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) begin
      case (sel)
        1:       w[i] = ((i % 10) < 5);
        2:       w[i] = (mix[i % 20] == "1");
        default: w[i] = (i % 2 == 1);
      endcase
    end
    return w;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  // Compare the word registered from the previous drive, then drive new inputs.
  task automatic step(bit en, int sel, logic [NL-1:0] ti, logic [NL-1:0] ri);
    @(negedge clk);
    if (exp_ok) begin
      for (int l = 0; l < NL; l++) begin
        check($sformatf("%s lane%0d tx", tx_tag[l], l), tx_data_out[l*W +: W], exp_tx[l]);
        check($sformatf("R8 lane%0d rx", l), rx_data_out[l*W +: W], exp_rx[l]);
      end
    end
    test_en  = en;
    test_sel = sel[1:0];
    tx_inv   = ti;
    rx_inv   = ri;
    for (int l = 0; l < NL; l++) begin
      logic [W-1:0] t, r, w;
      t = W'($urandom);
      r = W'($urandom);
      tx_data_in[l*W +: W] = t;
      rx_data_in[l*W +: W] = r;
      w = en ? model_pattern(sel) : t;
      if (ti[l]) w = ~w;
      exp_tx[l] = w;
      exp_rx[l] = ri[l] ? ~r : r;
      if (en) begin
        case (sel)
          0: tx_tag[l] = "R3/R9";
          1: tx_tag[l] = "R4/R9";
          2: tx_tag[l] = "R5/R9";
          default: tx_tag[l] = "R6/R9";
        endcase
      end else tx_tag[l] = "R2";
      if (ti[l]) tx_tag[l] = {tx_tag[l], "/R7"};
    end
    exp_ok = 1;
  endtask

  initial begin
    rst_n = 1'b0;
    test_en = 1'b0; test_sel = 2'b00; tx_inv = '1; rx_inv = '1;
    tx_data_in = '1; rx_data_in = '1;
    repeat (4) @(negedge clk);
    // R1: outputs held at zero under reset even with active inputs
    for (int l = 0; l < NL; l++) begin
      check($sformatf("R1 lane%0d tx", l), tx_data_out[l*W +: W], '0);
      check($sformatf("R1 lane%0d rx", l), rx_data_out[l*W +: W], '0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 plain pass-through, then each single-lane mask (R7, R8)
    for (int i = 0; i < 4; i++) step(0, 0, '0, '0);
    for (int l = 0; l < NL; l++) step(0, 0, NL'(1 << l), NL'(1 << l));
    // Each pattern select, masks off and varied (R3..R6, R7)
    for (int s = 0; s < 4; s++) begin
      step(1, s, '0, '0);
      step(1, s, 4'b0101, 4'b1010);
      step(1, s, '1, '0);
    end
    // Mode switching and random mix
    for (int i = 0; i < 300; i++)
      step(($urandom % 3) != 0, int'($urandom % 4), NL'($urandom), NL'($urandom));
    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule